// File: doc/BRIEF.md
# Interrupt Redirection Controller

The block routes sixteen interrupt input lines to processors by way of interrupt messages. Each line has a 64-bit routing entry that holds an 8-bit vector, an 8-bit destination ID, a mask and the mode bits. When a line goes from low to high and its entry allows delivery, the block records the event. It then sends one message that carries the vector, the destination and a broadcast flag.

Software reaches all internal state through two 32-bit locations on a small memory-mapped slave port. A select location names an internal register number, and a window location reads or writes the register named there. Each 64-bit routing entry takes two register numbers, one for each half. There are also an identification register, a read-only version register and an arbitration register that mirrors the identification value.

Messages leave on a valid/ready output. When several lines are waiting, the lowest-numbered line goes first. The block sends only edge-triggered, physically addressed, fixed-mode deliveries.

Top module: `irq_route_ctrl`

## Requirements
- R1: Only accesses with all four byte enables set (`bus_be` = 4'hF) at byte offset 0x00 or 0x10 are honoured. Any other write changes no state. Any other read returns zero on `bus_rdata`.
- R2: A read at offset 0x00 returns the full 32-bit select value last written there. Reads and writes at offset 0x10 reach the internal register whose number is in bits 7:0 of the select value. Read data shows on `bus_rdata` after the clock edge that takes the read and holds until the next read.
- R3: After reset the select value is 0, the identification value is 0 and no message is pending. Every routing entry reads 0x0001_0000_0001_0000, so every line starts masked.
- R4: Register numbers 0x10 to 0x2F map to the routing entries, with line = (number − 0x10) / 2. An even number reaches entry bits 31:0 and an odd number reaches bits 63:32. A write replaces only that half and leaves every other entry unchanged.
- R5: Register 0x01 (version) reads 0x0010_0011, which is the line count shifted left by 16, ORed with 0x11. Register 0x02 (arbitration) reads the identification value. Writes to either register have no effect.
- R6: A write to register 0x00 (identification) keeps only data bits 27:24 and clears the rest. Reads of any unimplemented register number (for example 0x03 or 0x30) return zero.
- R7: A message is raised only by a low-to-high change of a line. A line held high raises nothing more. A falling edge raises nothing.
- R8: A rising edge yields a message only when the entry has bit 16 (mask) = 0, bit 15 (trigger) = 0 (edge), bit 11 (destination mode) = 0 (physical) and bits 10:8 (delivery) = 000 (fixed). Otherwise the edge is dropped.
- R9: `msg_vector` is entry bits 7:0 and `msg_dest` is entry bits 63:56. `msg_bcast` is 1 exactly when the destination is 0xFF.
- R10: Each qualifying edge sets a pending flag for its line. `msg_valid` is high while any flag is set and stays high until `msg_ready` accepts the message. The lowest-numbered pending line is presented first, and its flag clears on acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_be | input | 4 | Byte enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_in | input | 16 | Interrupt input lines |
| msg_valid | output | 1 | A message is offered |
| msg_ready | input | 1 | The receiver accepts the offered message |
| msg_vector | output | 8 | Vector of the offered message |
| msg_dest | output | 8 | Destination ID of the offered message |
| msg_bcast | output | 1 | Message goes to all processors |

## Verification
Read data is registered once. It is due at the falling edge that follows the rising edge that took the access, so every bus task samples `bus_rdata` there. A line change driven at a falling edge is seen at the next rising edge, where it sets its pending flag, so `msg_valid` and the message fields are checked at the next falling edge, one cycle after the stimulus. An acceptance is driven for exactly one cycle. The pending flag clears at the rising edge that takes `msg_ready`, so the following falling edge is where the bench looks for the next message or for `msg_valid` low.

// File: rtl/irc_pkg.sv
// Package: shared constants and the message type of the interrupt
// redirection controller. Assumes 32-bit bus data and 8-bit register numbers.
package irc_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;
    localparam int REGN_W = 8;

    // bus offsets of the two honoured locations
    localparam logic [ADDR_W-1:0] OFF_SELECT = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_WINDOW = 8'h10;

    // internal register numbers
    localparam logic [REGN_W-1:0] RN_IDENT   = 8'h00;
    localparam logic [REGN_W-1:0] RN_VERSION = 8'h01;
    localparam logic [REGN_W-1:0] RN_ARBIT   = 8'h02;
    localparam logic [REGN_W-1:0] RN_TABLE   = 8'h10;

    // entry layout (low half)
    localparam int VEC_LSB   = 0;
    localparam int DLV_LSB   = 8;
    localparam int DSTM_BIT  = 11;
    localparam int TRIG_BIT  = 15;
    localparam int MASK_BIT  = 16;
    // entry layout (high half)
    localparam int DEST_LSB  = 24;

    localparam logic [DATA_W-1:0] HALF_RESET = 32'h0001_0000;
    localparam logic [DATA_W-1:0] IDENT_KEEP = 32'h0F00_0000;
    localparam logic [DATA_W-1:0] VER_LOW    = 32'h0000_0011;
    localparam logic [7:0]        DEST_ALL   = 8'hFF;

    typedef struct packed {
        logic [7:0] vector;
        logic [7:0] dest;
        logic       bcast;
    } irc_msg_t;
endpackage

// File: rtl/irc_bus_window.sv
// Module: bus window. Decodes the two honoured locations, holds the select
// register and registers read data. Assumes one-cycle access strobes and
// all other accesses being silently dropped (reads give zero).
module irc_bus_window
    import irc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] sel_q,
    output logic              reg_wr,
    output logic [REGN_W-1:0] reg_num,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_rdata
);
    logic at_sel, at_win, honoured;

    // decode: full-width access at one of the two offsets
    always_comb begin
        at_sel   = (bus_addr == OFF_SELECT);
        at_win   = (bus_addr == OFF_WINDOW);
        honoured = bus_en && (bus_be == 4'hF) && (at_sel || at_win);
    end

    // select register update
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= '0;
        else if (honoured && bus_we && at_sel)
            sel_q <= bus_wdata;
    end

    // read data register, zero for dropped reads
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_en && !bus_we) begin
            if (!honoured)
                bus_rdata <= '0;
            else if (at_sel)
                bus_rdata <= sel_q;
            else
                bus_rdata <= reg_rdata;
        end
    end

    // forward window accesses to the register file
    always_comb begin
        reg_wr    = honoured && bus_we && at_win;
        reg_num   = sel_q[REGN_W-1:0];
        reg_wdata = bus_wdata;
    end
endmodule

// File: rtl/irc_reg_file.sv
// Module: register file. Holds the identification value and the routing
// table (one low and one high half per line) and drives the read mux.
// Assumes NUM_PINS is a power of two, at most 64.
module irc_reg_file
    import irc_pkg::*;
#(
    parameter int NUM_PINS = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           reg_wr,
    input  logic [REGN_W-1:0]              reg_num,
    input  logic [DATA_W-1:0]              reg_wdata,
    output logic [DATA_W-1:0]              reg_rdata,
    output logic [NUM_PINS-1:0][DATA_W-1:0] tbl_lo,
    output logic [NUM_PINS-1:0][DATA_W-1:0] tbl_hi
);
    localparam int         IDX_W    = $clog2(NUM_PINS);
    localparam logic [8:0] TBL_REGS = 9'(2 * NUM_PINS);
    localparam logic [DATA_W-1:0] VER_VALUE = (DATA_W'(NUM_PINS) << 16) | VER_LOW;

    logic [DATA_W-1:0] ident_q;
    logic [8:0]        tbl_off;
    logic              in_tbl;
    logic [IDX_W-1:0]  pin_idx;
    logic              hi_half;

    // table decode from register number
    always_comb begin
        tbl_off = {1'b0, reg_num} - {1'b0, RN_TABLE};
        in_tbl  = (reg_num >= RN_TABLE) && (tbl_off < TBL_REGS);
        pin_idx = tbl_off[IDX_W:1];
        hi_half = tbl_off[0];
    end

    // identification register, only the ID field is kept
    always_ff @(posedge clk) begin
        if (!rst_n)
            ident_q <= '0;
        else if (reg_wr && reg_num == RN_IDENT)
            ident_q <= reg_wdata & IDENT_KEEP;
    end

    // routing table halves, one pair of registers per line
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n)
                tbl_lo[p] <= HALF_RESET;
            else if (reg_wr && in_tbl && !hi_half && pin_idx == IDX_W'(p))
                tbl_lo[p] <= reg_wdata;
        end
        always_ff @(posedge clk) begin
            if (!rst_n)
                tbl_hi[p] <= HALF_RESET;
            else if (reg_wr && in_tbl && hi_half && pin_idx == IDX_W'(p))
                tbl_hi[p] <= reg_wdata;
        end
    end

    // read mux for the data window
    always_comb begin
        reg_rdata = '0;
        case (reg_num)
            RN_IDENT:   reg_rdata = ident_q;
            RN_VERSION: reg_rdata = VER_VALUE;
            RN_ARBIT:   reg_rdata = ident_q;
            default: begin
                if (in_tbl)
                    reg_rdata = hi_half ? tbl_hi[pin_idx] : tbl_lo[pin_idx];
            end
        endcase
    end
endmodule

// File: rtl/irc_edge_pend.sv
// Module: edge detect, qualification, pending flags and message output.
// Assumes the inputs are already synchronous to clk. Message fields are
// taken from the table at presentation time.
module irc_edge_pend
    import irc_pkg::*;
#(
    parameter int NUM_PINS = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_PINS-1:0]             irq_in,
    input  logic [NUM_PINS-1:0][DATA_W-1:0] tbl_lo,
    input  logic [NUM_PINS-1:0][DATA_W-1:0] tbl_hi,
    input  logic                            msg_ready,
    output logic                            msg_valid,
    output irc_msg_t                        msg
);
    localparam int IDX_W = $clog2(NUM_PINS);

    logic [NUM_PINS-1:0] last_lvl, pend_q, qual, new_pend, clr;
    logic [NUM_PINS-1:0] unused_tbl;
    logic [IDX_W-1:0]    grant;

    // per-line delivery qualification from the entry mode bits
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_qual
        assign qual[p] = !tbl_lo[p][MASK_BIT] && !tbl_lo[p][TRIG_BIT] &&
                         !tbl_lo[p][DSTM_BIT] && (tbl_lo[p][DLV_LSB+:3] == 3'b000);
        assign unused_tbl[p] = ^{tbl_lo[p][31:17], tbl_lo[p][14:12], tbl_hi[p][23:0]};
    end

    // rising, qualified edges
    always_comb new_pend = irq_in & ~last_lvl & qual;

    // record each line's last level
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_lvl <= '0;
        else
            last_lvl <= irq_in;
    end

    // lowest-numbered pending line wins
    always_comb begin
        grant = '0;
        for (int i = NUM_PINS - 1; i >= 0; i--)
            if (pend_q[i]) grant = IDX_W'(i);
        msg_valid = |pend_q;
        clr       = '0;
        if (msg_valid && msg_ready)
            clr[grant] = 1'b1;
    end

    // pending flags: a new edge wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= '0;
        else
            pend_q <= (pend_q & ~clr) | new_pend;
    end

    // message fields of the granted line
    always_comb begin
        msg.vector = tbl_lo[grant][VEC_LSB+:8];
        msg.dest   = tbl_hi[grant][DEST_LSB+:8];
        msg.bcast  = (msg.dest == DEST_ALL);
    end
endmodule

// File: rtl/irq_route_ctrl.sv
// Module: top of the interrupt redirection controller. Wires the bus
// window, the register file and the edge/pending logic together.
// Assumes a synchronous active-low reset and synchronous interrupt lines.
module irq_route_ctrl
    import irc_pkg::*;
#(
    parameter int NUM_PINS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_en,
    input  logic                bus_we,
    input  logic [7:0]          bus_addr,
    input  logic [3:0]          bus_be,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] irq_in,
    output logic                msg_valid,
    input  logic                msg_ready,
    output logic [7:0]          msg_vector,
    output logic [7:0]          msg_dest,
    output logic                msg_bcast
);
    logic [DATA_W-1:0]               sel_value, reg_rdata, reg_wdata;
    logic                            reg_wr;
    logic [REGN_W-1:0]               reg_num;
    logic [NUM_PINS-1:0][DATA_W-1:0] tbl_lo, tbl_hi;
    irc_msg_t                        msg;

    irc_bus_window u_win (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .sel_q(sel_value), .reg_wr(reg_wr),
        .reg_num(reg_num), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    irc_reg_file #(.NUM_PINS(NUM_PINS)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_num(reg_num),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tbl_lo(tbl_lo), .tbl_hi(tbl_hi)
    );

    irc_edge_pend #(.NUM_PINS(NUM_PINS)) u_edge (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .tbl_lo(tbl_lo),
        .tbl_hi(tbl_hi), .msg_ready(msg_ready), .msg_valid(msg_valid), .msg(msg)
    );

    // expose message fields
    always_comb begin
        msg_vector = msg.vector;
        msg_dest   = msg.dest;
        msg_bcast  = msg.bcast;
    end
endmodule

// File: rtl/irc_checker.sv
// Module: property checker for irq_route_ctrl, attached by bind.
// Assumes it sees the top's ports plus the low byte of the select value.
module irc_checker #(
    parameter int NUM_PINS = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_en,
    input logic                bus_we,
    input logic [7:0]          bus_addr,
    input logic [3:0]          bus_be,
    input logic [31:0]         bus_rdata,
    input logic [NUM_PINS-1:0] irq_in,
    input logic                msg_valid,
    input logic                msg_ready,
    input logic [7:0]          sel_low
);
    localparam logic [31:0] VER_EXP = (32'(NUM_PINS) << 16) | 32'h11;

    assert_bad_read_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && bus_be != 4'hF) |=> (bus_rdata == 32'h0));

    assert_sel_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && bus_be == 4'hF && bus_addr == 8'h00)
        |=> (bus_rdata[7:0] == $past(sel_low)));

    assert_reset_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!msg_valid && bus_rdata == 32'h0));

    assert_version_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && bus_be == 4'hF && bus_addr == 8'h10 && sel_low == 8'h01)
        |=> (bus_rdata == VER_EXP));

    assert_msg_needs_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) |-> $past(|irq_in));

    assert_valid_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> msg_valid);
endmodule

bind irq_route_ctrl irc_checker #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_rdata(bus_rdata),
    .irq_in(irq_in), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .sel_low(sel_value[7:0])
);

// File: tb/tb_irq_route_ctrl.sv
`timescale 1ns/1ps
// Bench: directed scenarios, one task each, each checking its own results.
module tb_irq_route_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] irq_in = '0;
    logic        msg_valid, msg_ready = 1'b0, msg_bcast;
    logic [7:0]  msg_vector, msg_dest;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_route_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_in(irq_in), .msg_valid(msg_valid),
        .msg_ready(msg_ready), .msg_vector(msg_vector), .msg_dest(msg_dest),
        .msg_bcast(msg_bcast)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, input logic [3:0] be, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a; bus_be = be;
        @(negedge clk);
        bus_en = 1'b0;
        d = bus_rdata;
    endtask

    task automatic reg_wr(input logic [7:0] num, input logic [31:0] d);
        bus_wr(8'h00, 4'hF, {24'h0, num});
        bus_wr(8'h10, 4'hF, d);
    endtask

    task automatic reg_rd(input logic [7:0] num, output logic [31:0] d);
        bus_wr(8'h00, 4'hF, {24'h0, num});
        bus_rd(8'h10, 4'hF, d);
    endtask

    task automatic set_entry(input int p, input logic [31:0] lo, input logic [31:0] hi);
        reg_wr(8'(8'h10 + 2 * p), lo);
        reg_wr(8'(8'h11 + 2 * p), hi);
    endtask

    // drive a line at a falling edge; message state is due one cycle later
    task automatic drive_line(input int p, input logic v);
        @(negedge clk);
        irq_in[p] = v;
        @(negedge clk);
    endtask

    // one-cycle acceptance
    task automatic accept();
        @(negedge clk);
        msg_ready = 1'b1;
        @(negedge clk);
        msg_ready = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R3", "msg_valid after reset", 32'(msg_valid), 0);
        bus_rd(8'h00, 4'hF, d);
        chk("R3", "select after reset", d, 0);
        reg_rd(8'h00, d);
        chk("R3", "ident after reset", d, 0);
        for (int p = 0; p < 16; p++) begin
            reg_rd(8'(8'h10 + 2 * p), d);
            chk("R3", $sformatf("entry %0d low", p), d, 32'h0001_0000);
            reg_rd(8'(8'h11 + 2 * p), d);
            chk("R3", $sformatf("entry %0d high", p), d, 32'h0001_0000);
        end
    endtask

    task automatic t_bus_window();
        logic [31:0] d;
        bus_wr(8'h00, 4'hF, 32'hABCD_0001);
        bus_rd(8'h00, 4'hF, d);
        chk("R2", "select full readback", d, 32'hABCD_0001);
        bus_rd(8'h10, 4'hF, d);
        chk("R2", "window uses low byte of select", d, 32'h0010_0011);
        bus_wr(8'h00, 4'h3, 32'h0000_0002);
        bus_rd(8'h00, 4'hF, d);
        chk("R1", "partial write to select dropped", d, 32'hABCD_0001);
        bus_wr(8'h04, 4'hF, 32'h0000_0002);
        bus_rd(8'h00, 4'hF, d);
        chk("R1", "write at bad offset dropped", d, 32'hABCD_0001);
        bus_rd(8'h04, 4'hF, d);
        chk("R1", "read at bad offset", d, 0);
        bus_rd(8'h00, 4'h1, d);
        chk("R1", "partial read of select", d, 0);
        bus_rd(8'h10, 4'h7, d);
        chk("R1", "partial read of window", d, 0);
        reg_wr(8'h00, 32'h0300_0000);
        bus_wr(8'h00, 4'hF, 32'h0000_0000);
        bus_wr(8'h10, 4'hC, 32'h0F00_0000);
        bus_rd(8'h10, 4'hF, d);
        chk("R1", "partial write to window dropped", d, 32'h0300_0000);
    endtask

    task automatic t_ident();
        logic [31:0] d;
        reg_wr(8'h00, 32'hFFFF_FFFF);
        reg_rd(8'h00, d);
        chk("R6", "ident keeps bits 27:24", d, 32'h0F00_0000);
        reg_rd(8'h02, d);
        chk("R5", "arbitration mirrors ident", d, 32'h0F00_0000);
        reg_wr(8'h01, 32'h1234_5678);
        reg_rd(8'h01, d);
        chk("R5", "version read-only", d, 32'h0010_0011);
        reg_wr(8'h02, 32'h0500_0000);
        reg_rd(8'h02, d);
        chk("R5", "arbitration read-only", d, 32'h0F00_0000);
        reg_rd(8'h00, d);
        chk("R5", "arbitration write leaves ident", d, 32'h0F00_0000);
        reg_rd(8'h03, d);
        chk("R6", "unimplemented 0x03", d, 0);
        reg_rd(8'h30, d);
        chk("R6", "unimplemented 0x30", d, 0);
        reg_wr(8'h00, 32'h0000_0000);
    endtask

    task automatic t_halves();
        logic [31:0] d;
        reg_wr(8'h1A, 32'hA5A5_0042);
        reg_rd(8'h1A, d);
        chk("R4", "line 5 low written", d, 32'hA5A5_0042);
        reg_rd(8'h1B, d);
        chk("R4", "line 5 high untouched", d, 32'h0001_0000);
        reg_wr(8'h1B, 32'h3C00_0000);
        reg_rd(8'h1A, d);
        chk("R4", "line 5 low kept", d, 32'hA5A5_0042);
        reg_rd(8'h1B, d);
        chk("R4", "line 5 high written", d, 32'h3C00_0000);
        reg_rd(8'h18, d);
        chk("R4", "line 4 untouched", d, 32'h0001_0000);
        reg_rd(8'h1C, d);
        chk("R4", "line 6 untouched", d, 32'h0001_0000);
        reg_wr(8'h2F, 32'h7700_0000);
        reg_rd(8'h2F, d);
        chk("R4", "line 15 high (last number)", d, 32'h7700_0000);
        set_entry(5, 32'h0001_0000, 32'h0001_0000);
        set_entry(15, 32'h0001_0000, 32'h0001_0000);
    endtask

    task automatic t_edge();
        set_entry(3, 32'h0000_0031, 32'h0700_0000);
        drive_line(3, 1'b1);
        chk("R7", "valid on rising edge", 32'(msg_valid), 1);
        chk("R9", "vector", 32'(msg_vector), 32'h31);
        chk("R9", "dest", 32'(msg_dest), 32'h07);
        chk("R9", "unicast", 32'(msg_bcast), 0);
        accept();
        chk("R10", "cleared on accept", 32'(msg_valid), 0);
        repeat (3) @(negedge clk);
        chk("R7", "held level gives nothing", 32'(msg_valid), 0);
        drive_line(3, 1'b0);
        chk("R7", "falling edge gives nothing", 32'(msg_valid), 0);
        drive_line(3, 1'b1);
        chk("R7", "second rising edge", 32'(msg_valid), 1);
        accept();
        drive_line(3, 1'b0);
    endtask

    task automatic t_qualify();
        logic [31:0] bits [4] = '{32'h0001_0000, 32'h0000_8000, 32'h0000_0800, 32'h0000_0100};
        string names [4] = '{"masked", "level trigger", "logical dest", "non-fixed delivery"};
        for (int k = 0; k < 4; k++) begin
            set_entry(3, 32'h0000_0031 | bits[k], 32'h0700_0000);
            drive_line(3, 1'b1);
            chk("R8", names[k], 32'(msg_valid), 0);
            drive_line(3, 1'b0);
        end
        set_entry(3, 32'h0001_0000, 32'h0001_0000);
    endtask

    task automatic t_bcast();
        set_entry(7, 32'h0000_0077, 32'hFF00_0000);
        drive_line(7, 1'b1);
        chk("R9", "broadcast flag", 32'(msg_bcast), 1);
        chk("R9", "broadcast dest", 32'(msg_dest), 32'hFF);
        chk("R9", "broadcast vector", 32'(msg_vector), 32'h77);
        accept();
        drive_line(7, 1'b0);
        set_entry(7, 32'h0001_0000, 32'h0001_0000);
    endtask

    task automatic t_priority();
        set_entry(2, 32'h0000_0022, 32'h0100_0000);
        set_entry(9, 32'h0000_0099, 32'h0200_0000);
        @(negedge clk);
        irq_in[2] = 1'b1; irq_in[9] = 1'b1;
        @(negedge clk);
        chk("R10", "lowest line first", 32'(msg_vector), 32'h22);
        repeat (3) @(negedge clk);
        chk("R10", "valid held without ready", 32'(msg_valid), 1);
        chk("R10", "same message held", 32'(msg_vector), 32'h22);
        accept();
        chk("R10", "next line after accept", 32'(msg_vector), 32'h99);
        chk("R10", "next line dest", 32'(msg_dest), 32'h02);
        accept();
        chk("R10", "all delivered", 32'(msg_valid), 0);
        @(negedge clk);
        irq_in = '0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bus_window();
        t_ident();
        t_halves();
        t_edge();
        t_qualify();
        t_bcast();
        t_priority();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R10 watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule